// File: doc/BRIEF.md
# Partitioned Register Write-Lock Controller

This block guards a memory-mapped control-register space that is split into equal partitions. Each partition that carries a lock owns two key registers. Writes to the rest of that partition are let through only after a two-step key handshake: the first key goes to the first key register, then the second key goes to the second key register. Any other value written to either key register closes the partition at once. The block decodes each bus address to a partition, keeps one small key sequencer per partition, and drives a per-partition open/closed status. It also produces a write-qualify strobe that the downstream register storage uses to accept or drop each write, and it supplies the read value of the key registers.

The bus side is a plain single-cycle register port: address, write strobe, write data and read strobe. There is no valid/ready pair and no back-pressure. Every write or read is taken in the cycle its strobe is high. The write-qualify strobe and the read data are combinational in that same cycle. Status changes become visible on the clock edge that ends the key-register write.

Top module: `regwr_lock_ctrl`

## Requirements
- R1: After reset every partition is closed (`part_unlocked` is all zero) and no first step is armed.
- R2: The address splits into a partition index in bits 16:14 and an offset in bits 13:0. Only offsets below 2000h belong to the partition. Partitions 0, 1, 2, 3, 5 and 7 have locks. Writes to partitions 4 and 6, and to offsets 2000h–3FFFh of any partition, never pass, and key writes there change no status.
- R3: Within a partition, the first key register is at offset 1008h and the second at offset 100Ch. Writing 68EF3490h to the first, with bit 0 of the data ignored, arms the partition. A following write of D172BC5Ah to the second opens it, and the matching `part_unlocked` bit reads 1 from the next cycle on.
- R4: Any write to the first key register whose bits 31:1 differ from the first key, and any write of a value other than D172BC5Ah to the second key register, closes the partition and clears the armed step from the next cycle on.
- R5: Writing D172BC5Ah to the second key register without an armed first step leaves the partition closed.
- R6: While a partition is closed, `wr_pass` stays 0 for every write to its non-key offsets, except writes inside the exempt window.
- R7: While a partition is open, `wr_pass` is 1 in the same cycle for writes to offsets 0000h–17FFh other than the key registers. Offsets 1800h–1FFFh are read-only and never pass.
- R8: Writes to the exempt window at absolute addresses 04800h–048FFh always pass, whatever the lock state.
- R9: Writes to non-key registers, and key activity in one partition, leave the status of every other partition, and the partition's own open status, unchanged.
- R10: When `bus_rd` selects a key register, `rd_hit` is 1 in the same cycle. The first key register then reads bit 0 as that partition's open status with all other bits 0, and the second reads all zero. For any other read, `rd_hit` and `rd_data` are 0.
- R11: Writes to key registers are taken by this block and never raise `wr_pass`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 17 | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| wr_pass | output | 1 | Write accepted by downstream register storage in this cycle |
| rd_hit | output | 1 | The read targets a key register and `rd_data` is valid |
| rd_data | output | 32 | Key register read value |
| part_unlocked | output | 8 | Open status, one bit per partition index |

## Verification
The assertions assume that the bus drives at most one access per cycle. They also assume that the address and data are stable and known whenever a strobe is high, since the gate and the sequencers read them combinationally. The bench drives every access on the falling edge and holds it for one full cycle. It samples the combinational outputs a short delay after the drive and reads the status on the falling edge after the capturing rising edge. It never raises `bus_wr` and `bus_rd` together, and it leaves both strobes low between accesses.

// File: rtl/lock_pkg.sv
package lock_pkg;
  localparam logic [31:0] KEY_FIRST  = 32'h68EF_3490;
  localparam logic [31:0] KEY_SECOND = 32'hD172_BC5A;

  typedef struct packed {
    logic hit;     // inside a locked partition window
    logic is_k0;   // first key register
    logic is_k1;   // second key register
    logic ro;      // read-only offset
    logic exempt;  // lock-free window
  } dec_t;
endpackage

// File: rtl/lock_addr_decode.sv
module lock_addr_decode
  import lock_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int OFS_W = 14,
  parameter int NPART = 8,
  parameter logic [NPART-1:0] PRESENT = 8'hAF,
  parameter int WIN_BYTES = 8192,
  parameter int KICK0_OFS = 'h1008,
  parameter int KICK1_OFS = 'h100C,
  parameter int RO_LO = 'h1800,
  parameter int EXEMPT_LO = 'h04800,
  parameter int EXEMPT_HI = 'h048FF,
  localparam int PART_W = ADDR_W - OFS_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [PART_W-1:0] part_o,
  output dec_t              info_o
);
  logic [OFS_W-1:0] ofs;
  logic             in_win;
  logic             here;
  logic             kick_any;

  always_comb begin
    part_o   = addr[ADDR_W-1:OFS_W];
    ofs      = addr[OFS_W-1:0];
    in_win   = (32'(ofs) < WIN_BYTES);
    here     = in_win && PRESENT[part_o];
    info_o.hit    = here;
    info_o.is_k0  = here && (32'(ofs) == KICK0_OFS);
    info_o.is_k1  = here && (32'(ofs) == KICK1_OFS);
    kick_any      = info_o.is_k0 || info_o.is_k1;
    info_o.ro     = here && !kick_any && (32'(ofs) >= RO_LO);
    info_o.exempt = (32'(addr) >= EXEMPT_LO) && (32'(addr) <= EXEMPT_HI);
  end
endmodule

// File: rtl/lock_key_seq.sv
module lock_key_seq
  import lock_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_k0,
  input  logic        wr_k1,
  input  logic [31:0] wdata,
  output logic        open_o
);
  logic armed_q;
  logic open_q;
  logic k0_ok;
  logic k1_ok;

  assign k0_ok  = (wdata[31:1] == KEY_FIRST[31:1]);
  assign k1_ok  = (wdata == KEY_SECOND);
  assign open_o = open_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      open_q  <= 1'b0;
    end else if (wr_k0) begin
      if (k0_ok) begin
        armed_q <= 1'b1;
      end else begin
        armed_q <= 1'b0;
        open_q  <= 1'b0;
      end
    end else if (wr_k1) begin
      armed_q <= 1'b0;
      open_q  <= k1_ok && armed_q;
    end
  end

  // R3: opening needs the second key in the previous cycle
  a_r3_open_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(open_q) |-> $past(wr_k1 && k1_ok));
  // R4: a bad first key closes and disarms
  a_r4_bad_first_locks: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_k0 && !k0_ok) |=> (!open_q && !armed_q));
  // R4: a bad second key closes
  a_r4_bad_second_locks: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_k1 && !k1_ok) |=> !open_q);
  // R5: second key without an armed step keeps it closed
  a_r5_unarmed_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_k1 && !armed_q && !open_q) |=> !open_q);
  // R9: no key activity, no status change
  a_r9_hold_state: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_k0 && !wr_k1) |=> $stable(open_q));
endmodule

// File: rtl/lock_read_mux.sv
module lock_read_mux
  import lock_pkg::*;
#(
  parameter int NPART = 8,
  localparam int PART_W = $clog2(NPART)
) (
  input  logic              bus_rd,
  input  dec_t              info,
  input  logic [PART_W-1:0] part,
  input  logic [NPART-1:0]  open_vec,
  output logic              rd_hit,
  output logic [31:0]       rd_data
);
  always_comb begin
    rd_hit  = bus_rd && (info.is_k0 || info.is_k1);
    rd_data = '0;
    if (bus_rd && info.is_k0) rd_data[0] = open_vec[part];
  end
endmodule

// File: rtl/regwr_lock_ctrl.sv
module regwr_lock_ctrl
  import lock_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int OFS_W = 14,
  parameter logic [(1<<(ADDR_W-OFS_W))-1:0] PRESENT = 8'hAF,
  parameter int WIN_BYTES = 8192,
  parameter int KICK0_OFS = 'h1008,
  parameter int KICK1_OFS = 'h100C,
  parameter int RO_LO = 'h1800,
  parameter int EXEMPT_LO = 'h04800,
  parameter int EXEMPT_HI = 'h048FF,
  localparam int PART_W = ADDR_W - OFS_W,
  localparam int NPART = 1 << PART_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd,
  output logic              wr_pass,
  output logic              rd_hit,
  output logic [31:0]       rd_data,
  output logic [NPART-1:0]  part_unlocked
);
  logic [PART_W-1:0] part;
  dec_t              info;

  lock_addr_decode #(
    .ADDR_W(ADDR_W), .OFS_W(OFS_W), .NPART(NPART), .PRESENT(PRESENT),
    .WIN_BYTES(WIN_BYTES), .KICK0_OFS(KICK0_OFS), .KICK1_OFS(KICK1_OFS),
    .RO_LO(RO_LO), .EXEMPT_LO(EXEMPT_LO), .EXEMPT_HI(EXEMPT_HI)
  ) u_dec (
    .addr   (bus_addr),
    .part_o (part),
    .info_o (info)
  );

  for (genvar p = 0; p < NPART; p++) begin : g_part
    if (PRESENT[p]) begin : g_lock
      logic sel;
      assign sel = (part == PART_W'(p));
      lock_key_seq u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_k0  (bus_wr && info.is_k0 && sel),
        .wr_k1  (bus_wr && info.is_k1 && sel),
        .wdata  (bus_wdata),
        .open_o (part_unlocked[p])
      );
    end else begin : g_none
      assign part_unlocked[p] = 1'b0;
    end
  end

  always_comb begin
    wr_pass = bus_wr && (info.exempt ||
              (info.hit && !info.is_k0 && !info.is_k1 && !info.ro &&
               part_unlocked[part]));
  end

  lock_read_mux #(.NPART(NPART)) u_rd (
    .bus_rd   (bus_rd),
    .info     (info),
    .part     (part),
    .open_vec (part_unlocked),
    .rd_hit   (rd_hit),
    .rd_data  (rd_data)
  );

  // R6: closed partition drops non-exempt writes
  a_r6_closed_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && info.hit && !part_unlocked[part] && !info.exempt) |-> !wr_pass);
  // R7: read-only offsets never pass
  a_r7_ro_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && info.ro && !info.exempt) |-> !wr_pass);
  // R8: exempt window always passes
  a_r8_exempt_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && info.exempt) |-> wr_pass);
  // R11: key writes are consumed here
  a_r11_kick_consumed: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (info.is_k0 || info.is_k1)) |-> !wr_pass);
  // R2: partitions without a lock never open
  a_r2_absent_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (part_unlocked & ~PRESENT) == '0);
endmodule

// File: tb/regwr_lock_ctrl_tb.sv
`timescale 1ns/1ps
module regwr_lock_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [16:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic        wr_pass;
  logic        rd_hit;
  logic [31:0] rd_data;
  logic [7:0]  part_unlocked;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_unl = '0;

  localparam logic [31:0] K0 = 32'h68EF_3490;
  localparam logic [31:0] K1 = 32'hD172_BC5A;

  always #4 clk = ~clk;

  regwr_lock_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .wr_pass(wr_pass),
    .rd_hit(rd_hit), .rd_data(rd_data), .part_unlocked(part_unlocked)
  );

  function automatic logic [16:0] adr(int p, int ofs);
    return {3'(p), 14'(ofs)};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [16:0] a, logic [31:0] d, logic exp_pass, string tag);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    #1 chk(tag, 32'(wr_pass), 32'(exp_pass));
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [16:0] a, logic exp_hit, logic [31:0] exp_d, string tag);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1;
    chk({tag, " hit"}, 32'(rd_hit), 32'(exp_hit));
    chk({tag, " data"}, rd_data, exp_d);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic chk_status(string tag);
    chk(tag, 32'(part_unlocked), 32'(exp_unl));
  endtask

  task automatic t_reset;
    chk_status("R1 reset status");
    rd(adr(0, 'h1008), 1'b1, 32'h0, "R10 reset read first key");
  endtask

  task automatic t_closed_blocks;
    wr(adr(0, 'h0100), 32'h1234, 1'b0, "R6 closed write p0");
    wr(adr(3, 'h0000), 32'h1, 1'b0, "R6 closed write p3");
  endtask

  task automatic t_unlock_p0;
    wr(adr(0, 'h1008), K0 | 32'h1, 1'b0, "R11 first key write consumed");
    chk_status("R3 armed not yet open");
    wr(adr(0, 'h100C), K1, 1'b0, "R11 second key write consumed");
    exp_unl[0] = 1'b1;
    chk_status("R3 open after sequence");
    rd(adr(0, 'h1008), 1'b1, 32'h1, "R10 read open status");
    rd(adr(0, 'h100C), 1'b1, 32'h0, "R10 read second key");
    rd(adr(0, 'h0100), 1'b0, 32'h0, "R10 non-key read");
  endtask

  task automatic t_open_writes;
    wr(adr(0, 'h0100), 32'hA, 1'b1, "R7 open write passes");
    wr(adr(0, 'h17FC), 32'hB, 1'b1, "R7 top writable offset");
    wr(adr(0, 'h1800), 32'hC, 1'b0, "R7 read-only low edge");
    wr(adr(0, 'h1FFC), 32'hD, 1'b0, "R7 read-only high edge");
    chk_status("R9 open survives plain writes");
    wr(adr(1, 'h0100), 32'hE, 1'b0, "R9 other partition still closed");
    wr(adr(0, 'h2100), 32'hF, 1'b0, "R2 out-of-window offset");
  endtask

  task automatic t_wrong_keys;
    wr(adr(0, 'h100C), 32'hDEAD, 1'b0, "R4 bad second key");
    exp_unl[0] = 1'b0;
    chk_status("R4 closed by bad second key");
    wr(adr(0, 'h1008), K0, 1'b0, "R4 rearm");
    wr(adr(0, 'h100C), K1, 1'b0, "R4 reopen");
    exp_unl[0] = 1'b1;
    chk_status("R4 reopened");
    wr(adr(0, 'h1008), 32'h0BAD, 1'b0, "R4 bad first key");
    exp_unl[0] = 1'b0;
    chk_status("R4 closed by bad first key");
    wr(adr(0, 'h1008), K0, 1'b0, "R4 arm");
    wr(adr(0, 'h1008), 32'h1, 1'b0, "R4 bad first clears arm");
    wr(adr(0, 'h100C), K1, 1'b0, "R4 second after disarm");
    chk_status("R4 disarm keeps closed");
  endtask

  task automatic t_unarmed_second;
    wr(adr(2, 'h100C), K1, 1'b0, "R5 second key alone");
    chk_status("R5 stays closed");
    wr(adr(2, 'h1008), K0, 1'b0, "R5 arm p2");
    wr(adr(0, 'h100C), K1, 1'b0, "R9 second key other partition");
    chk_status("R9 p2 arm does not open p0");
  endtask

  task automatic t_exempt;
    wr(adr(1, 'h0800), 32'h5, 1'b1, "R8 exempt low edge");
    wr(adr(1, 'h08FC), 32'h6, 1'b1, "R8 exempt high edge");
    wr(adr(1, 'h0900), 32'h7, 1'b0, "R8 just past exempt");
    wr(adr(1, 'h07FC), 32'h8, 1'b0, "R8 just before exempt");
  endtask

  task automatic t_decode;
    wr(adr(4, 'h1008), K0, 1'b0, "R2 absent first key");
    wr(adr(4, 'h100C), K1, 1'b0, "R2 absent second key");
    chk_status("R2 absent partition stays closed");
    wr(adr(4, 'h0100), 32'h1, 1'b0, "R2 absent write");
    wr(adr(7, 'h1008), K0, 1'b0, "R2 arm p7");
    wr(adr(7, 'h100C), K1, 1'b0, "R2 open p7");
    exp_unl[7] = 1'b1;
    chk_status("R2 p7 open");
    wr(adr(5, 'h1008), K0, 1'b0, "R2 arm p5");
    wr(adr(5, 'h100C), K1, 1'b0, "R2 open p5");
    exp_unl[5] = 1'b1;
    chk_status("R2 p5 open");
    wr(adr(7, 'h0040), 32'h2, 1'b1, "R7 p7 write passes");
    wr(adr(6, 'h0040), 32'h2, 1'b0, "R2 p6 write blocked");
    rd(adr(7, 'h1008), 1'b1, 32'h1, "R10 read p7 status");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_closed_blocks();
    t_unlock_p0();
    t_open_writes();
    t_wrong_keys();
    t_unarmed_second();
    t_exempt();
    t_decode();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R1..: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule